// File: doc/BRIEF.md
# Run-time configurable SPI master shift engine

This block performs a single SPI master transfer per start request, with every transfer parameter taken at run time. On a start strobe it latches a transmit vector of up to 128 bits, a length in bits, a clock divider, the launch and capture edge choices, the bit order and an optional delay of one to four system clocks per direction. It then drives the serial clock, an active-low chip-select and serial data out, while it collects serial data in into a right-justified receive vector.

The serial clock idles low. Each half period lasts `div + 1` system clocks, so the serial clock runs at the system clock divided by `(div + 1) * 2`. Chip-select frames the transfer with half a serial period of margin on each side, unless the auto chip-select input holds it low permanently. A busy flag covers the whole transfer and drops one system clock after chip-select is released. Any start request made while busy is discarded.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset `sclk_o` is 0, `cs_no` is 1 (with `auto_cs_i` low), `busy_o` is 0, `sdo_o` is 0 and `rx_data_o` is all zeros. `sclk_o` stays 0 whenever the block is idle.
- R2: While busy, each half period of `sclk_o` lasts `div_i + 1` system clocks (one full period is `2*(div_i+1)`), and a transfer has exactly `len_i` rising edges.
- R3: `busy_o` rises and `cs_no` falls in the cycle after a start is accepted. The first rising edge of `sclk_o` follows `div_i + 1` clocks later. `cs_no` rises `div_i + 1` clocks after the last falling edge, and `busy_o` falls one clock after that.
- R4: With `lsb_first_i` = 0 the bits leave in the order `tx_data_i[len-1]` down to `tx_data_i[0]`. With `lsb_first_i` = 1 the order is `tx_data_i[0]` up to `tx_data_i[len-1]`. Bits at or above `len` are never sent.
- R5: With `tx_edge_i` = 1 the first bit is on `sdo_o` from the start cycle, and each following bit changes on a falling edge. With `tx_edge_i` = 0, `sdo_o` is cleared at start and each bit changes on a rising edge.
- R6: `rx_edge_i` = 1 samples `sdi_i` on each rising edge of `sclk_o`. `rx_edge_i` = 0 samples it on each falling edge. Exactly `len` samples are taken, and all of them are taken before `cs_no` rises.
- R7: Received bits are right-justified in `rx_data_o`. The j-th received bit (j from 0) lands at position `len-1-j` when MSB-first and at position `j` when LSB-first. All bits at or above `len` read 0, because the vector is cleared at start.
- R8: When `tx_dly_en_i` = 1, each data change on `sdo_o` occurs `tx_dly_i + 1` system clocks after the selected launch edge (codes 0..3 give 1..4 clocks). When disabled, it occurs on the same clock as the edge. The preloaded first bit is not delayed.
- R9: When `rx_dly_en_i` = 1, each sample of `sdi_i` is taken `rx_dly_i + 1` system clocks after the selected capture edge. A delay is only valid when it does not exceed `div_i + 1`.
- R10: When `auto_cs_i` = 1, `cs_no` is held low at all times, including while idle.
- R11: A start strobe while `busy_o` is 1 is ignored. The running transfer keeps its data, length and timing, and no second transfer follows.
- R12: A transfer of the full 128 bits is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| tx_data_i | input | 128 | Transmit vector |
| len_i | input | 8 | Transfer length in bits, 1..128 |
| div_i | input | 32 | Half-period divider; the half period is div+1 clocks |
| tx_edge_i | input | 1 | 1: change on falling edge, 0: change on rising edge |
| rx_edge_i | input | 1 | 1: sample on rising edge, 0: sample on falling edge |
| lsb_first_i | input | 1 | Bit order select |
| tx_dly_en_i | input | 1 | Enable the transmit launch delay |
| tx_dly_i | input | 2 | Transmit delay code, delay = code+1 clocks |
| rx_dly_en_i | input | 1 | Enable the receive sample delay |
| rx_dly_i | input | 2 | Receive delay code, delay = code+1 clocks |
| auto_cs_i | input | 1 | Hold chip-select asserted permanently |
| sdi_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Chip-select, active low |
| sdo_o | output | 1 | Serial data out |
| rx_data_o | output | 128 | Right-justified receive vector |
| busy_o | output | 1 | Transfer in progress |

## Verification
The embedded assertions check the following on every cycle:
- the serial clock toggles only on a divider tick and stays low while idle;
- the serial clock is never high outside the chip-select frame;
- the bit counters never pass the latched length, and both have reached it by the time the frame closes;
- busy drops right after the frame closes;
- the latched configuration is untouched by a start made while busy.

Only the bench scenarios can show the remaining properties:
- the exact bit order on the wire and where each received bit lands;
- the measured launch and capture delays against the edge choices;
- the half-period length and the framing margins;
- auto chip-select;
- that an ignored start leaves the wire traffic unchanged.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } xfer_st_e;
endpackage

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen #(
  parameter int DIV_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!run_i || cnt_q == div_i)  cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == div_i);

  // R2: ticks are spaced div+1 clocks apart
  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/spi_eng_evdly.sv
module spi_eng_evdly #(
  parameter int MAX_DLY = 4,
  localparam int CODE_W = $clog2(MAX_DLY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ev_o
);
  logic [MAX_DLY-1:0] pipe_q;

  for (genvar i = 0; i < MAX_DLY; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pipe_q[i] <= 1'b0;
      else if (i == 0) pipe_q[i] <= ev_i;
      else             pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
    end
  end

  assign ev_o = en_i ? pipe_q[code_i] : ev_i;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W  = 128,
  parameter int DIV_W   = 32,
  parameter int MAX_DLY = 4,
  localparam int LEN_W  = $clog2(DATA_W+1),
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int CODE_W = $clog2(MAX_DLY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_edge_i,
  input  logic              rx_edge_i,
  input  logic              lsb_first_i,
  input  logic              tx_dly_en_i,
  input  logic [CODE_W-1:0] tx_dly_i,
  input  logic              rx_dly_en_i,
  input  logic [CODE_W-1:0] rx_dly_i,
  input  logic              auto_cs_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o
);
  import spi_eng_pkg::*;

  xfer_st_e          st_q;
  logic [DIV_W-1:0]  div_q;
  logic [LEN_W-1:0]  len_q, txc_q, rxc_q, len_m1;
  logic [LEN_W:0]    ecnt_q, len2;
  logic              lsb_q, txe_q, rxe_q, txden_q, rxden_q;
  logic [CODE_W-1:0] txdc_q, rxdc_q;
  logic [DATA_W-1:0] txd_q, rx_q;
  logic              sclk_q, sdo_q, cs_q;
  logic              running, tick, last_edge, edge_ev, start_ok;
  logic              tx_raw, rx_raw, tx_ev, rx_ev, tx_go, rx_go;
  logic [IDX_W-1:0]  tx_idx, rx_idx, first_idx;

  assign start_ok  = (st_q == ST_IDLE) && start_i;
  assign running   = (st_q == ST_RUN);
  assign len2      = {len_q, 1'b0};
  assign len_m1    = len_q - 1'b1;
  assign last_edge = (ecnt_q == len2);
  assign edge_ev   = tick && !last_edge;
  // launch / capture edge selection before optional delay
  assign tx_raw    = edge_ev && (txe_q ? sclk_q : !sclk_q);
  assign rx_raw    = edge_ev && (rxe_q ? !sclk_q : sclk_q);
  assign tx_go     = tx_ev && (txc_q < len_q);
  assign rx_go     = rx_ev && (rxc_q < len_q);
  assign tx_idx    = lsb_q ? txc_q[IDX_W-1:0] : IDX_W'(len_m1 - txc_q);
  assign rx_idx    = lsb_q ? rxc_q[IDX_W-1:0] : IDX_W'(len_m1 - rxc_q);
  assign first_idx = lsb_first_i ? '0 : IDX_W'(len_i - 1'b1);

  spi_eng_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i, .rst_ni, .run_i(running), .div_i(div_q), .tick_o(tick)
  );

  spi_eng_evdly #(.MAX_DLY(MAX_DLY)) u_tx_dly (
    .clk_i, .rst_ni, .ev_i(tx_raw), .en_i(txden_q), .code_i(txdc_q), .ev_o(tx_ev)
  );

  spi_eng_evdly #(.MAX_DLY(MAX_DLY)) u_rx_dly (
    .clk_i, .rst_ni, .ev_i(rx_raw), .en_i(rxden_q), .code_i(rxdc_q), .ev_o(rx_ev)
  );

  // sequencing and configuration latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      div_q   <= '0;
      len_q   <= '0;
      lsb_q   <= 1'b0;
      txe_q   <= 1'b0;
      rxe_q   <= 1'b0;
      txden_q <= 1'b0;
      rxden_q <= 1'b0;
      txdc_q  <= '0;
      rxdc_q  <= '0;
      txd_q   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b0;
      ecnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_RUN;
          div_q   <= div_i;
          len_q   <= len_i;
          lsb_q   <= lsb_first_i;
          txe_q   <= tx_edge_i;
          rxe_q   <= rx_edge_i;
          txden_q <= tx_dly_en_i;
          rxden_q <= rx_dly_en_i;
          txdc_q  <= tx_dly_i;
          rxdc_q  <= rx_dly_i;
          txd_q   <= tx_data_i;
          sclk_q  <= 1'b0;
          cs_q    <= 1'b1;
          ecnt_q  <= '0;
        end
        ST_RUN: if (tick) begin
          if (last_edge) begin
            cs_q <= 1'b0;
            st_q <= ST_FIN;
          end else begin
            sclk_q <= !sclk_q;
            ecnt_q <= ecnt_q + 1'b1;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // shift datapath
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txc_q <= '0;
      rxc_q <= '0;
      sdo_q <= 1'b0;
      rx_q  <= '0;
    end else if (start_ok) begin
      rx_q  <= '0;
      rxc_q <= '0;
      if (tx_edge_i) begin
        sdo_q <= tx_data_i[first_idx];
        txc_q <= LEN_W'(1);
      end else begin
        sdo_q <= 1'b0;
        txc_q <= '0;
      end
    end else begin
      if (tx_go) begin
        sdo_q <= txd_q[tx_idx];
        txc_q <= txc_q + 1'b1;
      end
      if (rx_go) begin
        rx_q[rx_idx] <= sdi_i;
        rxc_q        <= rxc_q + 1'b1;
      end
    end
  end

  assign sclk_o    = sclk_q;
  assign sdo_o     = sdo_q;
  assign cs_no     = !(cs_q || auto_cs_i);
  assign rx_data_o = rx_q;
  assign busy_o    = (st_q != ST_IDLE);

  assert_sclk_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sclk_q);
  assert_sclk_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_q) |-> $past(tick));
  assert_sclk_framed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> cs_q);
  assert_busy_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_q) |=> !busy_o);
  assert_tx_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txc_q <= len_q);
  assert_tx_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_q) |-> (txc_q == len_q));
  assert_rx_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_q) |-> (rxc_q == len_q));
  assert_rx_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxc_q <= len_q);
  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(len_q) && $stable(txd_q) && $stable(lsb_q)));
endmodule

// File: tb/spi_shift_engine_bench.sv
module spi_shift_engine_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] tx_data_i = '0;
  logic [7:0]   len_i = '0;
  logic [31:0]  div_i = '0;
  logic         tx_edge_i = 1'b0, rx_edge_i = 1'b0, lsb_first_i = 1'b0;
  logic         tx_dly_en_i = 1'b0, rx_dly_en_i = 1'b0, auto_cs_i = 1'b0;
  logic [1:0]   tx_dly_i = '0, rx_dly_i = '0;
  logic         sdi_i = 1'b0;
  logic         sclk_o, cs_no, sdo_o, busy_o;
  logic [127:0] rx_data_o;

  int n_run = 0, n_fail = 0;
  bit exp_q[$];
  bit cur_txe = 1'b0;
  logic [127:0] slv_pat = '0;
  int  slv_len = 0, slv_k = 0, slv_cd = 0;
  bit  slv_rxe = 1'b0, slv_late = 1'b0;

  always #10 clk_i = !clk_i;

  spi_shift_engine u_spi_shift_engine (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares the wire against the queued expected bits
  logic mon_prev = 1'b0;
  always @(negedge clk_i) begin
    if ((sclk_o && !mon_prev && cur_txe) || (!sclk_o && mon_prev && !cur_txe)) begin
      if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected launched bit", 128'(sdo_o), 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(sdo_o == e, "R4/R5", "sdo bit", 128'(sdo_o), 128'(e));
      end
    end
    mon_prev = sclk_o;
  end

  // slave model driving sdi
  logic slv_pb = 1'b0, slv_ps = 1'b0;
  always @(negedge clk_i) begin
    if (busy_o && !slv_pb) begin
      slv_k = 0; slv_cd = 0;
      if (slv_rxe && !slv_late) begin sdi_i = slv_pat[0]; slv_k = 1; end
    end
    if (slv_cd > 0) begin
      slv_cd--;
      if (slv_cd == 0 && slv_k < slv_len) begin sdi_i = slv_pat[slv_k]; slv_k++; end
    end
    if (sclk_o && !slv_ps) begin
      if (slv_late) slv_cd = 2;
      else if (!slv_rxe && slv_k < slv_len) begin sdi_i = slv_pat[slv_k]; slv_k++; end
    end
    if (!sclk_o && slv_ps && slv_rxe && !slv_late && slv_k < slv_len) begin
      sdi_i = slv_pat[slv_k]; slv_k++;
    end
    slv_pb = busy_o;
    slv_ps = sclk_o;
  end

  task automatic run_xfer(input logic [127:0] tx, input logic [127:0] pat, input int len,
                          input int div, input bit lsb, input bit txe, input bit rxe,
                          input bit tden, input int tdc, input bit rden, input int rdc,
                          input bit late, input int exp_sdo_dly, input bit inject);
    logic [127:0] exp_rx = '0;
    int t = 0, n_r = 0, t_r1 = -1, t_rl = -1, per_bad = 0, t_fl = -1, t_cs = -1;
    int t_b = -1, t_sc = -1;
    logic ps, psdo, pcs;
    @(negedge clk_i);
    tx_data_i = tx; len_i = 8'(len); div_i = div; lsb_first_i = lsb;
    tx_edge_i = txe; rx_edge_i = rxe; tx_dly_en_i = tden; tx_dly_i = 2'(tdc);
    rx_dly_en_i = rden; rx_dly_i = 2'(rdc);
    cur_txe = txe;
    for (int j = 0; j < len; j++) begin
      exp_q.push_back(lsb ? tx[j] : tx[len-1-j]);
      exp_rx[lsb ? j : len-1-j] = pat[j];
    end
    slv_pat = pat; slv_len = len; slv_rxe = rxe; slv_late = late;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    t = 1;
    chk(busy_o == 1'b1, "R3", "busy after start", 128'(busy_o), 1);
    chk(cs_no == 1'b0, "R3", "cs after start", 128'(cs_no), 0);
    ps = sclk_o; psdo = sdo_o; pcs = cs_no;
    while (t_b < 0 && t < 5000) begin
      if (inject && t == div + 3) begin
        start_i = 1'b1; tx_data_i = ~tx; len_i = 8'd3; lsb_first_i = !lsb;
      end else start_i = 1'b0;
      @(negedge clk_i);
      t++;
      if (sclk_o && !ps) begin
        n_r++;
        if (t_r1 < 0) t_r1 = t;
        else if (t - t_rl != 2*(div+1)) per_bad++;
        t_rl = t;
      end
      if (!sclk_o && ps) t_fl = t;
      if (t_r1 >= 0 && t_sc < 0 && sdo_o != psdo) t_sc = t - t_r1;
      if (cs_no && !pcs) t_cs = t;
      if (!busy_o) t_b = t;
      ps = sclk_o; psdo = sdo_o; pcs = cs_no;
    end
    start_i = 1'b0;
    chk(n_r == len, "R2", "rising edge count", 128'(n_r), 128'(len));
    chk(per_bad == 0, "R2", "bad periods", 128'(per_bad), 0);
    chk(t_r1 == div + 2, "R3", "cs to first rise", 128'(t_r1 - 1), 128'(div + 1));
    if (auto_cs_i) chk(t_cs == -1, "R10", "cs released under auto", 128'(t_cs), 0);
    else begin
      chk(t_cs - t_fl == div + 1, "R3", "last fall to cs rise", 128'(t_cs - t_fl), 128'(div + 1));
      chk(t_b - t_cs == 1, "R3", "cs rise to busy drop", 128'(t_b - t_cs), 1);
    end
    chk(rx_data_o == exp_rx, "R6/R7/R9", "rx vector", rx_data_o, exp_rx);
    if (exp_sdo_dly >= 0)
      chk(t_sc == exp_sdo_dly, "R8", "launch delay", 128'(t_sc), 128'(exp_sdo_dly));
    chk(exp_q.size() == 0, "R4", "bits not launched", 128'(exp_q.size()), 0);
    exp_q.delete();
    repeat (4) @(negedge clk_i);
    chk(busy_o == 1'b0 && sclk_o == 1'b0, "R1/R11", "stays idle after transfer",
        128'({busy_o, sclk_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(sclk_o == 1'b0, "R1", "reset sclk", 128'(sclk_o), 0);
    chk(cs_no == 1'b1, "R1", "reset cs", 128'(cs_no), 1);
    chk(busy_o == 1'b0, "R1", "reset busy", 128'(busy_o), 0);
    chk(sdo_o == 1'b0, "R1", "reset sdo", 128'(sdo_o), 0);
    chk(rx_data_o == '0, "R1", "reset rx", rx_data_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R12: full length, MSB first, launch on fall, sample on rise
    run_xfer({4{32'hC3A5_9617}}, {4{32'h1E2D_3C4B}}, 128, 4, 0, 1, 1, 0, 0, 0, 0, 0, -1, 0);
    // R4 R5 R6 R7: short MSB-first, clears bits above len
    run_xfer(128'hB6, 128'h5A, 8, 4, 0, 1, 1, 0, 0, 0, 0, 0, -1, 0);
    // R4 R5 R6 R7: LSB-first, launch on rise, sample on fall, no delay -> change at the rise
    run_xfer(128'h1ACD, 128'h0F35, 13, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: transmit delay code 2 -> 3 clocks after the rise
    run_xfer(128'hA5, 128'h3C, 8, 5, 0, 0, 1, 1, 2, 0, 0, 0, 3, 0);
    // R8: transmit delay code 3 on falling launches
    run_xfer(128'h2D3, 128'h1B1, 10, 5, 1, 1, 0, 1, 3, 0, 0, 0, -1, 0);
    // R9: receive delay code 3, slave changes data 2.5 clocks after the rise
    run_xfer(128'h96, 128'hC9, 8, 5, 0, 1, 1, 0, 0, 1, 3, 1, -1, 0);
    // R9: receive delay on falling capture
    run_xfer(128'h71, 128'h4E, 7, 5, 1, 1, 0, 0, 0, 1, 1, 0, -1, 0);
    // single-bit boundary
    run_xfer(128'h1, 128'h1, 1, 3, 0, 1, 1, 0, 0, 0, 0, 0, -1, 0);
    // R11: start pulsed mid-transfer with other data
    run_xfer(128'h9C3, 128'h6A5, 12, 4, 0, 1, 1, 0, 0, 0, 0, 0, -1, 1);
    // R10: auto chip-select
    @(negedge clk_i);
    auto_cs_i = 1'b1;
    @(negedge clk_i);
    chk(cs_no == 1'b0, "R10", "auto cs idle", 128'(cs_no), 0);
    run_xfer(128'h9, 128'h6, 4, 3, 0, 1, 0, 0, 0, 0, 0, 0, -1, 0);
    chk(cs_no == 1'b0, "R10", "auto cs after", 128'(cs_no), 0);
    auto_cs_i = 1'b0;
    @(negedge clk_i);
    chk(cs_no == 1'b1, "R10", "cs idle without auto", 128'(cs_no), 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule